// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the register front end of a two-channel serial communications controller. It sits on a byte-wide bus and gives each channel, A and B, a control port and a data port. Most registers are reached indirectly. A control write first loads a per-channel register pointer, and the next control access goes to the register it names. After that access the pointer falls back to zero. The same control writes at pointer zero also carry commands that clear interrupts.

Each channel keeps its own receive and transmit interrupt state, with separate pending and in-service flags. One shared vector register is rewritten whenever an interrupt is raised or cleared, and a summary register shows every pending source. Both channels feed a single interrupt request line. The block also decodes each channel's line settings into registered output fields: parity, stop bits, character length, and a baud divisor built from the time constant and clock multiplier. The bit shifter itself is outside this block. Received bytes arrive on a valid/data strobe, transmitted bytes leave on a one-cycle strobe, and a break condition arrives as a pulse.

A bus write and a bus read are never asserted in the same cycle. A control or data read returns its byte on `bus_rdata` in the cycle after the read strobe.

Top module: `scc_dual_regif`

## Requirements
- R1: `bus_addr[2]` picks the channel (1 = A, 0 = B) and `bus_addr[1]` picks the port (0 = control, 1 = data); `bus_addr[0]` is ignored.
- R2: A control write while the channel's pointer is 0 loads the pointer from data bits 2:0, plus 8 when bits 5:3 hold command 1; bits 5:3 equal to 5 clear the transmit interrupt, and equal to 7 clear the receive interrupt if it is in service, or else the transmit interrupt if that one is.
- R3: A control write while the pointer is nonzero stores the byte in write register [pointer] and returns the pointer to 0; a control read returns read register [pointer] (RR0 status, RR1 = 0x07, RR2 vector on channel B, RR3 summary on channel A, RR12/RR13, others 0) and returns the pointer to 0.
- R4: A write to register 9 whose bits 7:6 are nonzero is a reset and is not stored: bit 6 resets channel B, bit 7 resets channel A, both set resets both; otherwise register 9 is stored.
- R5: After any reset RR0 is 0x44 (0x7C on a channel flagged in parameter `CHAN_DIS`), RR1 0x07, RR2 0x00, the interrupt line is low, and the write registers take their defaults (WR4 0x04, WR9 0xC0, WR11 0x08, WR14 0x30, WR15 0xF8, rest 0), so line outputs show no parity, one stop bit, 5 data bits and baud divisor 2.
- R6: A received byte is taken only while WR3 bit 0 is set and RR0 bit 0 is clear (`rx_ready`); taking it sets RR0 bit 0 and raises the receive interrupt; a data read returns the byte, clears RR0 bit 0 and clears the receive interrupt.
- R7: A data write raises the transmit interrupt and, when WR5 bit 3 is set, pulses `tx_valid` for one cycle with the byte in the next cycle.
- R8: Raising a receive interrupt marks it in service only if the channel's transmit interrupt is not in service, and vice versa; a raise that gets in service writes the vector: A receive 0x0C/0x30, A transmit 0x08/0x10, B receive 0x04/0x20, B transmit 0x00 (low/high, chosen by WR9 bit 4 of the channel concerned).
- R9: Clearing an interrupt drops its pending and in-service flags and writes the no-interrupt vector 0x06 (0x60 with WR9 bit 4); the channel's other interrupt, if still pending, is then raised again under R8.
- R10: RR3 shows pending interrupts as bit 5 A receive, bit 4 A transmit, bit 2 B receive, bit 1 B transmit, and reads 0 with nothing pending.
- R11: `irq` is high exactly when some channel has WR1 bit 1 set and a pending transmit interrupt, or WR1 bits 4:3 equal to 01 or 10 and a pending receive interrupt, or WR15 bit 7 set and its break flag (RR0 bit 7) set.
- R12: Line outputs follow the write registers one cycle later: parity enable WR4 bit 0, even parity WR4 bit 1, two stop bits when WR4 bits 3:2 are 11, data bits 5/7/6/8 for WR5 bits 6:5 = 00/01/10/11, and baud divisor ({WR13, WR12} + 2) shifted left by 0, 4, 5 or 6 for WR4 bits 7:6.
- R13: Bytes written to WR12 and WR13 read back through RR12 and RR13.
- R14: A `brk_in` pulse sets the channel's RR0 bit 7 until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Bit 2 channel, bit 1 port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after `bus_rd` |
| rx_valid | input | 2 | Received-byte strobe per channel (bit 1 = A) |
| rx_data | input | 16 | Received byte per channel (15:8 = A) |
| rx_ready | output | 2 | Channel can take a byte |
| brk_in | input | 2 | Break-detected pulse per channel |
| tx_valid | output | 2 | Transmit strobe per channel |
| tx_data | output | 16 | Transmit byte per channel |
| irq | output | 1 | Combined interrupt request |
| par_en | output | 2 | Parity enabled |
| par_even | output | 2 | Even parity selected |
| two_stop | output | 2 | Two stop bits selected |
| data_bits | output | 8 | Character length per channel (4 bits each) |
| baud_div | output | 46 | Reference-clock divisor per channel (23 bits each) |

## Verification
The assertions check several rules on every cycle. Neither channel ever has receive and transmit in service together. An in-service flag never stands without its pending flag. The interrupt line never rises without a source. Every transmit strobe comes from a data write one cycle earlier. Every pointer access returns the pointer to zero, and a taken byte blocks the receiver. Only the directed scenarios can show the orderings that depend on history. One is the deferred receive that becomes in service when a reset-highest-in-service command clears a transmit. Others are the exact vector codes under both status-high settings, the reset targets chosen by register 9, and the decoded line fields and baud divisor.

// File: rtl/scc_pkg.sv
// Shared constants, interrupt state type and interrupt-state update functions.
// Assumes channel index 0 is B and index 1 is A throughout the block.
package scc_pkg;
    localparam int NCH    = 2;
    localparam int DW     = 8;
    localparam int NREG   = 16;
    localparam int PW     = $clog2(NREG);
    localparam int TCW    = 2 * DW;
    localparam int MAXSH  = 6;
    localparam int BAUD_W = TCW + 1 + MAXSH;
    localparam int CH_B   = 0;
    localparam int CH_A   = 1;

    localparam logic [2:0]    CMD_HIGH    = 3'd1;
    localparam logic [2:0]    CMD_CLR_TX  = 3'd5;
    localparam logic [2:0]    CMD_CLR_IUS = 3'd7;
    localparam logic [PW-1:0] REG_RESET   = PW'(9);
    localparam logic [PW-1:0] REG_TC_LO   = PW'(12);
    localparam logic [PW-1:0] REG_TC_HI   = PW'(13);

    typedef struct packed {
        logic [NCH-1:0] rxp;
        logic [NCH-1:0] txp;
        logic [NCH-1:0] rxs;
        logic [NCH-1:0] txs;
        logic [DW-1:0]  vec;
    } irq_st_t;

    // Vector for a source; c = 1 means channel A.
    function automatic logic [DW-1:0] vec_code(input logic c, input logic tx, input logic hi);
        if (c) return tx ? (hi ? 8'h10 : 8'h08) : (hi ? 8'h30 : 8'h0C);
        return tx ? 8'h00 : (hi ? 8'h20 : 8'h04);
    endfunction

    function automatic logic [DW-1:0] vec_none(input logic hi);
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic irq_st_t f_set_rx(input irq_st_t s, input logic c, input logic hi);
        s.rxp[c] = 1'b1;
        if (!s.txs[c]) begin
            s.rxs[c] = 1'b1;
            s.vec    = vec_code(c, 1'b0, hi);
        end
        return s;
    endfunction

    function automatic irq_st_t f_set_tx(input irq_st_t s, input logic c, input logic hi);
        s.txp[c] = 1'b1;
        if (!s.rxs[c]) begin
            s.txs[c] = 1'b1;
            s.vec    = vec_code(c, 1'b1, hi);
        end
        return s;
    endfunction

    function automatic irq_st_t f_clr_rx(input irq_st_t s, input logic c, input logic hi);
        s.rxp[c] = 1'b0;
        s.rxs[c] = 1'b0;
        s.vec    = vec_none(hi);
        if (s.txp[c]) s = f_set_tx(s, c, hi);
        return s;
    endfunction

    function automatic irq_st_t f_clr_tx(input irq_st_t s, input logic c, input logic hi);
        s.txp[c] = 1'b0;
        s.txs[c] = 1'b0;
        s.vec    = vec_none(hi);
        if (s.rxp[c]) s = f_set_rx(s, c, hi);
        return s;
    endfunction

    function automatic logic [DW-1:0] wr_default(input int i);
        case (i)
            4:       return 8'h04;
            9:       return 8'hC0;
            11:      return 8'h08;
            14:      return 8'h30;
            15:      return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/scc_wregs.sv
// One channel's write-register file with reset defaults.
// Assumes the parent never raises we for register 0 or for a reset write.
module scc_wregs
    import scc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ch_rst,
    input  logic                     we,
    input  logic [PW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  regs
);
    // Load defaults on any reset, else store the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || ch_rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= wr_default(i);
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/scc_irq_ctrl.sv
// Interrupt pending / in-service state of both channels and the shared vector.
// Events in one cycle are folded in a fixed order: channel resets, bus
// clears, transmit raise, then receive raises of B and A.
module scc_irq_ctrl
    import scc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_rst,
    input  logic [NCH-1:0] stat_hi,
    input  logic [NCH-1:0] set_rx,
    input  logic [NCH-1:0] set_tx,
    input  logic [NCH-1:0] clr_rx,
    input  logic [NCH-1:0] clr_tx,
    input  logic [NCH-1:0] clr_ius,
    output irq_st_t        st_q
);
    irq_st_t nx;

    // Apply this cycle's events to the state one after another.
    always_comb begin
        nx = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (chan_rst[c]) begin
                nx.rxp[c] = 1'b0;
                nx.txp[c] = 1'b0;
                nx.rxs[c] = 1'b0;
                nx.txs[c] = 1'b0;
                if (c == CH_B) nx.vec = '0;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (clr_ius[c]) begin
                if (nx.rxs[c])      nx = f_clr_rx(nx, 1'(c), stat_hi[c]);
                else if (nx.txs[c]) nx = f_clr_tx(nx, 1'(c), stat_hi[c]);
            end
            if (clr_tx[c]) nx = f_clr_tx(nx, 1'(c), stat_hi[c]);
            if (clr_rx[c]) nx = f_clr_rx(nx, 1'(c), stat_hi[c]);
            if (set_tx[c]) nx = f_set_tx(nx, 1'(c), stat_hi[c]);
        end
        for (int c = 0; c < NCH; c++) begin
            if (set_rx[c]) nx = f_set_rx(nx, 1'(c), stat_hi[c]);
        end
    end

    // Hold the interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= nx;
    end
endmodule

// File: rtl/scc_line_dec.sv
// Registered decode of one channel's line settings; the baud divisor is the
// time constant plus two, shifted by the clock multiplier (no divider).
module scc_line_dec
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wr_fmt,
    input  logic [DW-1:0]     wr_tx,
    input  logic [DW-1:0]     wr_tc_lo,
    input  logic [DW-1:0]     wr_tc_hi,
    output logic              par_en,
    output logic              par_even,
    output logic              two_stop,
    output logic [3:0]        data_bits,
    output logic [BAUD_W-1:0] baud_div
);
    logic [TCW:0]       base;
    logic [BAUD_W-1:0]  div_nx;
    logic [3:0]         bits_nx;

    // Form divisor and character length from the register fields.
    always_comb begin
        base = {1'b0, wr_tc_hi, wr_tc_lo} + (TCW+1)'(2);
        case (wr_fmt[7:6])
            2'd0:    div_nx = BAUD_W'(base);
            2'd1:    div_nx = BAUD_W'(base) << 4;
            2'd2:    div_nx = BAUD_W'(base) << 5;
            default: div_nx = BAUD_W'(base) << MAXSH;
        endcase
        case (wr_tx[6:5])
            2'd0:    bits_nx = 4'd5;
            2'd1:    bits_nx = 4'd7;
            2'd2:    bits_nx = 4'd6;
            default: bits_nx = 4'd8;
        endcase
    end

    // Register the decoded fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_en    <= 1'b0;
            par_even  <= 1'b0;
            two_stop  <= 1'b0;
            data_bits <= 4'd5;
            baud_div  <= BAUD_W'(2);
        end else begin
            par_en    <= wr_fmt[0];
            par_even  <= wr_fmt[1];
            two_stop  <= (wr_fmt[3:2] == 2'b11);
            data_bits <= bits_nx;
            baud_div  <= div_nx;
        end
    end
endmodule

// File: rtl/scc_dual_regif.sv
// Two-channel serial controller register interface: bus decode, register
// pointers, receive/break status, transmit strobe, read mux and interrupt.
// Assumes bus_wr and bus_rd are never high together; read data is registered.
module scc_dual_regif
    import scc_pkg::*;
#(
    parameter logic [1:0] CHAN_DIS = 2'b00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [1:0]           rx_valid,
    input  logic [15:0]          rx_data,
    output logic [1:0]           rx_ready,
    input  logic [1:0]           brk_in,
    output logic [1:0]           tx_valid,
    output logic [15:0]          tx_data,
    output logic                 irq,
    output logic [1:0]           par_en,
    output logic [1:0]           par_even,
    output logic [1:0]           two_stop,
    output logic [7:0]           data_bits,
    output logic [45:0]          baud_div
);
    logic                    sel;
    logic                    is_data;
    logic                    ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic [PW-1:0]           cur_ptr;
    logic [2:0]              cmd;
    logic                    rst_wr;
    logic [NCH-1:0]          chan_rst;
    logic [NCH-1:0]          set_rx, set_tx, clr_rx, clr_tx, clr_ius, stat_hi;
    logic [NCH-1:0]          rx_pend, tx_pend, rx_svc, tx_svc, brk_q, req;
    logic [PW-1:0]           ptr_q [NCH];
    logic [NREG-1:0][DW-1:0] wr_q  [NCH];
    logic [DW-1:0]           rr0   [NCH];
    logic [DW-1:0]           rxbuf [NCH];
    logic [DW-1:0]           summary;
    logic [DW-1:0]           rd_mux;
    irq_st_t                 irq_st;

    assign sel     = bus_addr[2];
    assign is_data = bus_addr[1];
    assign ctl_wr  = bus_wr & ~is_data;
    assign dat_wr  = bus_wr &  is_data;
    assign ctl_rd  = bus_rd & ~bus_wr & ~is_data;
    assign dat_rd  = bus_rd & ~bus_wr &  is_data;
    assign cur_ptr = ptr_q[sel];
    assign cmd     = bus_wdata[5:3];
    assign rst_wr  = ctl_wr && (cur_ptr == REG_RESET) && (bus_wdata[7:6] != 2'b00);
    assign chan_rst = rst_wr ? {bus_wdata[7], bus_wdata[6]} : '0;

    assign rx_pend = irq_st.rxp;
    assign tx_pend = irq_st.txp;
    assign rx_svc  = irq_st.rxs;
    assign tx_svc  = irq_st.txs;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic          here;
        logic          accept;
        logic          rxav;
        logic          brk;
        logic          txv;
        logic [DW-1:0] txd;

        assign here = (sel == 1'(c));

        scc_wregs u_wregs (
            .clk   (clk),
            .rst_n (rst_n),
            .ch_rst(chan_rst[c]),
            .we    (ctl_wr && here && (cur_ptr != '0) && !rst_wr),
            .waddr (cur_ptr),
            .wdata (bus_wdata),
            .regs  (wr_q[c])
        );

        scc_line_dec u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_fmt   (wr_q[c][4]),
            .wr_tx    (wr_q[c][5]),
            .wr_tc_lo (wr_q[c][REG_TC_LO]),
            .wr_tc_hi (wr_q[c][REG_TC_HI]),
            .par_en   (par_en[c]),
            .par_even (par_even[c]),
            .two_stop (two_stop[c]),
            .data_bits(data_bits[c*4 +: 4]),
            .baud_div (baud_div[c*BAUD_W +: BAUD_W])
        );

        // Pointer: loaded at pointer 0, otherwise returned to 0 by any access.
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst[c]) begin
                ptr_q[c] <= '0;
            end else if (here && ctl_wr) begin
                if (ptr_q[c] == '0) ptr_q[c] <= {cmd == CMD_HIGH, bus_wdata[2:0]};
                else                ptr_q[c] <= '0;
            end else if (here && ctl_rd) begin
                ptr_q[c] <= '0;
            end
        end

        assign rx_ready[c] = wr_q[c][3][0] & ~rxav;
        assign accept      = rx_valid[c] & rx_ready[c] & ~chan_rst[c];

        // Receive buffer, byte-available flag and break flag.
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst[c]) begin
                rxav     <= 1'b0;
                brk      <= 1'b0;
                rxbuf[c] <= '0;
            end else begin
                if (accept)              rxav <= 1'b1;
                else if (here && dat_rd) rxav <= 1'b0;
                if (accept)              rxbuf[c] <= rx_data[c*DW +: DW];
                if (brk_in[c])           brk  <= 1'b1;
            end
        end

        // One-cycle transmit strobe when the transmitter is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                txv <= 1'b0;
                txd <= '0;
            end else begin
                txv <= dat_wr && here && wr_q[c][5][3];
                if (dat_wr && here) txd <= bus_wdata;
            end
        end

        assign tx_valid[c]          = txv;
        assign tx_data[c*DW +: DW]  = txd;
        assign brk_q[c]             = brk;
        assign rr0[c] = {brk, (CHAN_DIS[c] ? 5'b11111 : 5'b10001), 1'b0, rxav};

        assign set_rx[c]  = accept;
        assign set_tx[c]  = dat_wr && here;
        assign clr_rx[c]  = dat_rd && here;
        assign clr_tx[c]  = ctl_wr && here && (cur_ptr == '0) && (cmd == CMD_CLR_TX);
        assign clr_ius[c] = ctl_wr && here && (cur_ptr == '0) && (cmd == CMD_CLR_IUS);
        assign stat_hi[c] = wr_q[c][REG_RESET][4];

        assign req[c] = (wr_q[c][1][1] & tx_pend[c])
                      | (((wr_q[c][1][4:3] == 2'b01) || (wr_q[c][1][4:3] == 2'b10)) & rx_pend[c])
                      | (wr_q[c][15][7] & brk);
    end

    scc_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_rst(chan_rst),
        .stat_hi (stat_hi),
        .set_rx  (set_rx),
        .set_tx  (set_tx),
        .clr_rx  (clr_rx),
        .clr_tx  (clr_tx),
        .clr_ius (clr_ius),
        .st_q    (irq_st)
    );

    assign irq     = |req;
    assign summary = {2'b00, rx_pend[CH_A], tx_pend[CH_A], 1'b0,
                      rx_pend[CH_B], tx_pend[CH_B], 1'b0};

    // Select the read register named by the channel's pointer.
    always_comb begin
        case (cur_ptr)
            PW'(0):    rd_mux = rr0[sel];
            PW'(1):    rd_mux = 8'h07;
            PW'(2):    rd_mux = (sel == 1'(CH_B)) ? irq_st.vec : '0;
            PW'(3):    rd_mux = (sel == 1'(CH_A)) ? summary : '0;
            REG_TC_LO: rd_mux = wr_q[sel][REG_TC_LO];
            REG_TC_HI: rd_mux = wr_q[sel][REG_TC_HI];
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (ctl_rd) bus_rdata <= rd_mux;
        else if (dat_rd) bus_rdata <= rxbuf[sel];
    end
endmodule

// File: rtl/scc_dual_regif_chk.sv
// Assertion checker for scc_dual_regif, attached with bind below.
module scc_dual_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] rx_valid,
    input logic [1:0] rx_ready,
    input logic [1:0] tx_valid,
    input logic       irq,
    input logic [3:0] ptr_b,
    input logic [3:0] ptr_a,
    input logic [1:0] rx_pend,
    input logic [1:0] tx_pend,
    input logic [1:0] rx_svc,
    input logic [1:0] tx_svc,
    input logic [1:0] brk
);
    a_r3_wr_ptr_return: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[1] && !bus_addr[2] && ptr_b != 4'd0) |=> (ptr_b == 4'd0));

    a_r3_rd_ptr_return: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr[1] && bus_addr[2]) |=> (ptr_a == 4'd0));

    a_r6_full_blocks_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid[0] && rx_ready[0] && !bus_wr) |=> !rx_ready[0]);

    a_r6_full_blocks_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid[1] && rx_ready[1] && !bus_wr) |=> !rx_ready[1]);

    a_r7_tx_origin_a: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[1] |-> $past(bus_wr && bus_addr[1] && bus_addr[2]));

    a_r7_tx_origin_b: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[0] |-> $past(bus_wr && bus_addr[1] && !bus_addr[2]));

    a_r8_svc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_svc & tx_svc) == 2'b00));

    a_r8_svc_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (((rx_svc & ~rx_pend) | (tx_svc & ~tx_pend)) == 2'b00));

    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rx_pend | tx_pend | brk) != 2'b00));
endmodule

bind scc_dual_regif scc_dual_regif_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .tx_valid(tx_valid),
    .irq     (irq),
    .ptr_b   (ptr_q[0]),
    .ptr_a   (ptr_q[1]),
    .rx_pend (rx_pend),
    .tx_pend (tx_pend),
    .rx_svc  (rx_svc),
    .tx_svc  (tx_svc),
    .brk     (brk_q)
);

// File: tb/scc_dual_regif_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module scc_dual_regif_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] B_CTL = 3'b000, B_DAT = 3'b010, A_CTL = 3'b100, A_DAT = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, d_rdata;
    logic [1:0]  rx_valid = '0, brk_in = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_ready, tx_valid, par_en, par_even, two_stop, irq_v;
    logic [15:0] tx_data;
    logic        irq, d_irq;
    logic [7:0]  data_bits;
    logic [45:0] baud_div;
    logic [1:0]  d_rx_ready, d_tx_valid, d_par_en, d_par_even, d_two_stop;
    logic [15:0] d_tx_data;
    logic [7:0]  d_data_bits;
    logic [45:0] d_baud_div;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign irq_v = {d_irq, irq};

    scc_dual_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .brk_in(brk_in), .tx_valid(tx_valid), .tx_data(tx_data),
        .irq(irq), .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
        .data_bits(data_bits), .baud_div(baud_div));

    scc_dual_regif #(.CHAN_DIS(2'b01)) u_dis (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(d_rdata), .rx_valid(2'b00), .rx_data(16'h0),
        .rx_ready(d_rx_ready), .brk_in(2'b00), .tx_valid(d_tx_valid), .tx_data(d_tx_data),
        .irq(d_irq), .par_en(d_par_en), .par_even(d_par_even), .two_stop(d_two_stop),
        .data_bits(d_data_bits), .baud_div(d_baud_div));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wreg(input logic ch_a, input logic [3:0] r, input logic [7:0] v);
        bwr(ch_a ? A_CTL : B_CTL, {4'h0, r});
        bwr(ch_a ? A_CTL : B_CTL, v);
    endtask

    task automatic rreg(input logic ch_a, input logic [3:0] r, output logic [7:0] d);
        if (r != 4'd0) bwr(ch_a ? A_CTL : B_CTL, {4'h0, r});
        brd(ch_a ? A_CTL : B_CTL, d);
    endtask

    task automatic pulse_rx(input int c, input logic [7:0] d);
        @(negedge clk);
        rx_valid[c] = 1'b1; rx_data[c*8 +: 8] = d;
        @(negedge clk);
        rx_valid[c] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R5 irq after reset", irq, 1'b0);
        chk("R5 baud_div B", baud_div[22:0], 23'd2);
        chk("R5 data_bits A", data_bits[7:4], 4'd5);
        chk("R5 line flags", {par_en, par_even, two_stop}, 6'b0);
        chk("R6 rx_ready off with WR3 clear", rx_ready, 2'b00);
        rreg(1'b1, 4'd0, d); chk("R5 RR0 A", d, 8'h44);
        chk("R5 RR0 A disabled-flag instance", d_rdata, 8'h44);
        rreg(1'b0, 4'd0, d); chk("R5 RR0 B", d, 8'h44);
        chk("R5 RR0 B disabled", d_rdata, 8'h7C);
        rreg(1'b0, 4'd1, d); chk("R5 RR1 B", d, 8'h07);
        rreg(1'b0, 4'd2, d); chk("R5 RR2 vector", d, 8'h00);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 empty", d, 8'h00);
    endtask

    task automatic t_ptr_line();
        logic [7:0] d;
        wreg(1'b1, 4'd12, 8'h34);
        rreg(1'b1, 4'd12, d); chk("R13 RR12 mirror", d, 8'h34);
        brd(A_CTL, d); chk("R3 pointer back to 0 after read", d, 8'h44);
        bwr(A_CTL, 8'h05); bwr(A_CTL, 8'h00);
        brd(A_CTL, d); chk("R3 pointer back to 0 after write", d, 8'h44);
        wreg(1'b1, 4'd13, 8'h01);
        rreg(1'b1, 4'd13, d); chk("R13 RR13 mirror", d, 8'h01);
        rreg(1'b0, 4'd12, d); chk("R1 channel B untouched", d, 8'h00);
        wreg(1'b1, 4'd4, 8'hCF);
        wreg(1'b1, 4'd5, 8'h28);
        @(negedge clk);
        chk("R12 parity enable A", par_en, 2'b10);
        chk("R12 even parity A", par_even, 2'b10);
        chk("R12 two stop A", two_stop, 2'b10);
        chk("R12 data bits A", data_bits[7:4], 4'd7);
        chk("R12 baud_div A x64", baud_div[45:23], 23'd19840);
        chk("R12 baud_div B", baud_div[22:0], 23'd2);
        wreg(1'b0, 4'd4, 8'h44);
        wreg(1'b0, 4'd5, 8'h40);
        @(negedge clk);
        chk("R12 B x16 tc0", baud_div[22:0], 23'd32);
        chk("R12 B 6 bits", data_bits[3:0], 4'd6);
        chk("R12 B one stop", two_stop[0], 1'b0);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        wreg(1'b0, 4'd3, 8'h01);
        wreg(1'b0, 4'd1, 8'h10);
        chk("R6 rx_ready B", rx_ready[0], 1'b1);
        pulse_rx(0, 8'h5A);
        chk("R6 rx_ready drops", rx_ready[0], 1'b0);
        chk("R11 irq on rx", irq, 1'b1);
        pulse_rx(0, 8'hA5);
        rreg(1'b0, 4'd0, d); chk("R6 RR0 B byte avail", d, 8'h45);
        rreg(1'b0, 4'd2, d); chk("R8 vector B rx low", d, 8'h04);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 B rx", d, 8'h04);
        brd(B_DAT, d); chk("R6 data read keeps first byte", d, 8'h5A);
        chk("R6 irq cleared by read", irq, 1'b0);
        rreg(1'b0, 4'd2, d); chk("R9 vector none low", d, 8'h06);
        rreg(1'b0, 4'd0, d); chk("R6 RR0 cleared", d, 8'h44);
        chk("R6 A rx_ready off", rx_ready[1], 1'b0);
        pulse_rx(1, 8'h33);
        rreg(1'b1, 4'd0, d); chk("R6 A byte refused", d, 8'h44);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = A_DAT; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk);
        chk("R7 tx strobe A", tx_valid, 2'b10);
        chk("R7 tx byte A", tx_data[15:8], 8'h77);
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R7 strobe one cycle", tx_valid, 2'b00);
        chk("R11 irq masked by WR1", irq, 1'b0);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 A tx", d, 8'h10);
        rreg(1'b0, 4'd2, d); chk("R8 vector A tx low", d, 8'h08);
        wreg(1'b1, 4'd1, 8'h02);
        chk("R11 irq tx enabled", irq, 1'b1);
        bwr(A_CTL, 8'h28);
        chk("R2 clear tx cmd", irq, 1'b0);
        rreg(1'b0, 4'd2, d); chk("R9 vector none", d, 8'h06);
        @(negedge clk);
        bus_addr = B_DAT; bus_wdata = 8'h12; bus_wr = 1'b1;
        @(negedge clk);
        chk("R7 no strobe with tx disabled", tx_valid, 2'b00);
        bus_wr = 1'b0;
        rreg(1'b0, 4'd2, d); chk("R8 vector B tx", d, 8'h00);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 B tx", d, 8'h02);
        bwr(B_CTL, 8'h28);
        rreg(1'b1, 4'd3, d); chk("R9 RR3 after B clear", d, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] d;
        wreg(1'b1, 4'd1, 8'h12);
        wreg(1'b1, 4'd3, 8'h01);
        bwr(A_DAT, 8'h11);
        pulse_rx(1, 8'h99);
        rreg(1'b0, 4'd2, d); chk("R8 rx deferred while tx in service", d, 8'h08);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 both A", d, 8'h30);
        bwr(A_CTL, 8'h38);
        rreg(1'b0, 4'd2, d); chk("R9 rx raised after tx clear", d, 8'h0C);
        rreg(1'b1, 4'd3, d); chk("R10 RR3 A rx only", d, 8'h20);
        chk("R11 irq rx pending", irq, 1'b1);
        brd(A_DAT, d); chk("R6 A byte", d, 8'h99);
        chk("R11 irq idle", irq, 1'b0);
        wreg(1'b1, 4'd9, 8'h10);
        pulse_rx(1, 8'h42);
        rreg(1'b0, 4'd2, d); chk("R8 vector A rx high", d, 8'h30);
        bwr(A_CTL, 8'h38);
        rreg(1'b0, 4'd2, d); chk("R2 cmd 7 clears rx, none high", d, 8'h60);
        rreg(1'b1, 4'd0, d); chk("R2 cmd 7 leaves byte flag", d, 8'h45);
        brd(A_DAT, d);
    endtask

    task automatic t_brk();
        logic [7:0] d;
        @(negedge clk); brk_in = 2'b01;
        @(negedge clk); brk_in = 2'b00;
        chk("R11 irq on break", irq, 1'b1);
        rreg(1'b0, 4'd0, d); chk("R14 RR0 B break", d, 8'hC4);
        wreg(1'b1, 4'd9, 8'h40);
        chk("R4 B reset clears irq", irq, 1'b0);
        rreg(1'b0, 4'd0, d); chk("R4 B RR0 reset", d, 8'h44);
        chk("R4 B WR3 reset", rx_ready[0], 1'b0);
        @(negedge clk);
        chk("R4 A kept", baud_div[45:23], 23'd19840);
        chk("R4 B line reset", baud_div[22:0], 23'd2);
        wreg(1'b0, 4'd9, 8'h80);
        @(negedge clk);
        chk("R4 A reset", baud_div[45:23], 23'd2);
        chk("R4 A data bits reset", data_bits[7:4], 4'd5);
        wreg(1'b0, 4'd3, 8'h01);
        wreg(1'b1, 4'd3, 8'h01);
        chk("R6 both ready", rx_ready, 2'b11);
        wreg(1'b1, 4'd9, 8'hC0);
        chk("R4 both reset", rx_ready, 2'b00);
        chk("R5 irq both", irq_v, 2'b00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_line();
        t_rx();
        t_tx();
        t_prio();
        t_brk();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule